// File: doc/BRIEF.md
# Serial-Load DES Round Key Generator

This block produces the sixteen 48-bit round keys of the DES cipher from a 64-bit key that arrives one byte per clock over an 8-bit port. Parity bits are dropped on arrival. The seven key bits of each byte go straight into their places in two 28-bit rotating halves, following Permuted Choice 1. A one-cycle setup step follows the last byte. After it, the block presents the Permuted Choice 2 selection of the two halves as the current round key, together with a 4-bit round index.

A cipher datapath sits next to this block. It pulses `step` once per round to get the next key. Both halves rotate together, each only within itself, by one or two places per round. In encrypt order the rotation is to the left. In decrypt order it is to the right, so the keys come out last round first. No key table is stored: the order is reversed by rotation alone, and the first decrypt key needs no rotation before it.

Top module: `des_key_sched_ser`

## Requirements
- R1: While `rst_n` is low, and after it is released, `key_ready` is 0 and `round_idx` is 0.
- R2: Bytes are accepted on rising edges where `key_valid` is 1. Byte k (k = 0 first) carries key bits 8k+1 to 8k+8 in the cipher's numbering, with the lowest-numbered bit on `key_byte[7]`. `key_ready` stays 0 on the edge that accepts the eighth byte. It rises on the following edge.
- R3: `key_byte[0]` of every byte is parity and has no effect on any round key.
- R4: With encrypt mode (`mode` = 0), `round_idx` = i shows round key i+1. `round_key[47]` is key bit 1 of the round and `round_key[0]` is bit 48. For key 0x133457799BBCDFF1 the first key is 0x1B02EFFC7072 and the second is 0x79AED9DBC9E5.
- R5: With decrypt mode (`mode` = 1), `round_idx` = i shows round key 16-i. The first key, round key 16 (0xCB3D8B0E17F5 for the key of R4), appears without any step.
- R6: Each accepted `step` raises `round_idx` by one modulo 16 and moves `round_key` to the next key of the order. After index 15 a step returns to index 0 and the first key of the order.
- R7: `step` has no effect while `key_ready` is 0, including the setup cycle. Without a step, `round_idx` and `round_key` hold.
- R8: A byte presented while `key_ready` is 1 drops `key_ready` on that edge and begins a new load. The byte position counts modulo 8.
- R9: `mode` is sampled only with the eighth byte. Changing it at any other time leaves the key order unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| key_byte | input | 8 | Key byte, bit 0 is parity |
| key_valid | input | 1 | `key_byte` is accepted on this edge |
| mode | input | 1 | 0 encrypt order, 1 decrypt order (taken with the eighth byte) |
| step | input | 1 | Advance to the next round key |
| key_ready | output | 1 | Round key outputs are valid |
| round_idx | output | 4 | Position within the current order, 0 to 15 |
| round_key | output | 48 | Current round key, bit 1 at the MSB |

## Verification
The bench uses the default parameters, which the cipher fixes: 8 bytes, 28-bit halves and 16 rounds. With these values a full cycle of keys, the wrap from index 15 back to 0, and a reload in the middle of a cycle each take only tens of cycles. The bench can therefore run several complete orders in both modes. Each key is compared against a model that builds the schedule from cumulative rotation offsets rather than from rotating registers. The published vectors of one well-known key anchor the bit ordering.

// File: rtl/des_ks_pkg.sv
package des_ks_pkg;
  localparam int BYTE_W  = 8;
  localparam int NBYTES  = 8;
  localparam int HALF_W  = 28;
  localparam int CD_W    = 2 * HALF_W;
  localparam int RK_W    = 48;
  localparam int NROUNDS = 16;
  localparam int IDX_W   = $clog2(NROUNDS);
  localparam int CNT_W   = $clog2(NBYTES);

  // half-register position (1..56) -> key bit number (1..64)
  localparam int unsigned PC1_T [CD_W] = '{
    57, 49, 41, 33, 25, 17,  9,  1, 58, 50, 42, 34, 26, 18,
    10,  2, 59, 51, 43, 35, 27, 19, 11,  3, 60, 52, 44, 36,
    63, 55, 47, 39, 31, 23, 15,  7, 62, 54, 46, 38, 30, 22,
    14,  6, 61, 53, 45, 37, 29, 21, 13,  5, 28, 20, 12,  4};

  // round key bit (1..48) -> half-register position (1..56)
  localparam int unsigned PC2_T [RK_W] = '{
    14, 17, 11, 24,  1,  5,  3, 28, 15,  6, 21, 10,
    23, 19, 12,  4, 26,  8, 16,  7, 27, 20, 13,  2,
    41, 52, 31, 37, 47, 55, 30, 40, 51, 45, 33, 48,
    44, 49, 39, 56, 34, 53, 46, 42, 50, 36, 29, 32};

  // bit r set: round r+1 rotates by one place, else by two
  localparam logic [NROUNDS-1:0] ONE_PLACE = 16'h8103;

  // rotate both halves independently; position 1 sits at the MSB
  function automatic logic [CD_W-1:0] rot_cd(input logic [CD_W-1:0] v,
                                             input logic right,
                                             input logic two);
    logic [HALF_W-1:0] h [2];
    h[0] = v[CD_W-1:HALF_W];
    h[1] = v[HALF_W-1:0];
    for (int i = 0; i < 2; i++) begin
      if (!right)
        h[i] = two ? {h[i][HALF_W-3:0], h[i][HALF_W-1:HALF_W-2]}
                   : {h[i][HALF_W-2:0], h[i][HALF_W-1]};
      else
        h[i] = two ? {h[i][1:0], h[i][HALF_W-1:2]}
                   : {h[i][0], h[i][HALF_W-1:1]};
    end
    return {h[0], h[1]};
  endfunction
endpackage

// File: rtl/des_ks_seq.sv
module des_ks_seq
  import des_ks_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_valid,
  input  logic             mode_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             prime_o,
  output logic             ready_o,
  output logic             dec_o,
  output logic             step_en_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [CNT_W-1:0] cnt_q, cnt_nx;
  logic [IDX_W-1:0] idx_q, idx_nx;
  logic prime_q, prime_nx, ready_q, ready_nx, dec_q, dec_nx;
  logic last_byte, step_en;

  assign last_byte = key_valid && (cnt_q == CNT_W'(NBYTES - 1));
  assign step_en   = ready_q && step_i && !key_valid;

  always_comb begin
    cnt_nx   = key_valid ? cnt_q + CNT_W'(1) : cnt_q;
    prime_nx = last_byte;
    ready_nx = ready_q;
    if (key_valid)    ready_nx = 1'b0;
    else if (prime_q) ready_nx = 1'b1;
    dec_nx   = last_byte ? mode_i : dec_q;
    idx_nx   = idx_q;
    if (prime_q)      idx_nx = '0;
    else if (step_en) idx_nx = idx_q + IDX_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      prime_q <= 1'b0;
      ready_q <= 1'b0;
      dec_q   <= 1'b0;
      idx_q   <= '0;
    end else begin
      cnt_q   <= cnt_nx;
      prime_q <= prime_nx;
      ready_q <= ready_nx;
      dec_q   <= dec_nx;
      idx_q   <= idx_nx;
    end
  end

  assign cnt_o     = cnt_q;
  assign prime_o   = prime_q;
  assign ready_o   = ready_q;
  assign dec_o     = dec_q;
  assign step_en_o = step_en;
  assign idx_o     = idx_q;

  // R8
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |=> !ready_q);
  // R2
  ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_q) |-> $past(last_byte, 2));
  // R6
  idx_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_en && (idx_q == IDX_W'(NROUNDS - 1)) |=> idx_q == '0);
  // R7
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q && !step_i && !key_valid |=> $stable(idx_q));
  // R9
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !last_byte |=> $stable(dec_q));
endmodule

// File: rtl/des_ks_cdreg.sv
module des_ks_cdreg
  import des_ks_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BYTE_W-1:1] key_bits,
  input  logic             key_valid,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             prime_i,
  input  logic             dec_i,
  input  logic             step_en_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [CD_W-1:0]  cd_o
);
  logic [CD_W-1:0] cd_q, cd_nx, ld_val;
  logic [IDX_W-1:0] enc_r, dec_r;
  logic two;

  // each half-register position listens to one byte slot and one bit
  for (genvar p = 1; p <= CD_W; p++) begin : g_ld
    localparam int unsigned SRC = PC1_T[p-1] - 1;
    localparam int unsigned BI  = SRC / BYTE_W;
    localparam int unsigned BB  = BYTE_W - 1 - (SRC % BYTE_W);
    assign ld_val[CD_W-p] = (cnt_i == CNT_W'(BI)) ? key_bits[BB] : cd_q[CD_W-p];
  end

  assign enc_r = idx_i + IDX_W'(1);
  assign dec_r = IDX_W'(NROUNDS - 1) - idx_i;
  assign two   = !ONE_PLACE[dec_i ? dec_r : enc_r];

  always_comb begin
    cd_nx = cd_q;
    if (key_valid)               cd_nx = ld_val;
    else if (prime_i && !dec_i)  cd_nx = rot_cd(cd_q, 1'b0, 1'b0);
    else if (step_en_i)          cd_nx = rot_cd(cd_q, dec_i, two);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cd_q <= '0;
    else        cd_q <= cd_nx;
  end

  assign cd_o = cd_q;

  // R6
  half_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_en_i |=> $countones(cd_q[CD_W-1:HALF_W]) == $past($countones(cd_q[CD_W-1:HALF_W])));
  // R7
  cd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !key_valid && !prime_i && !step_en_i |=> $stable(cd_q));
endmodule

// File: rtl/des_ks_pc2.sv
module des_ks_pc2
  import des_ks_pkg::*;
(
  input  logic [CD_W-1:0] cd_i,
  output logic [RK_W-1:0] rk_o
);
  logic [CD_W-1:0] cd_unused;
  assign cd_unused = cd_i;

  for (genvar j = 1; j <= RK_W; j++) begin : g_sel
    assign rk_o[RK_W-j] = cd_i[CD_W-PC2_T[j-1]];
  end
endmodule

// File: rtl/des_key_sched_ser.sv
module des_key_sched_ser
  import des_ks_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] key_byte,
  input  logic              key_valid,
  input  logic              mode,
  input  logic              step,
  output logic              key_ready,
  output logic [IDX_W-1:0]  round_idx,
  output logic [RK_W-1:0]   round_key
);
  logic [1:0] rs_q;
  logic rst_i, parity_unused;
  logic [CNT_W-1:0] cnt;
  logic prime, dec, step_en;
  logic [CD_W-1:0] cd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];
  assign parity_unused = key_byte[0];

  des_ks_seq u_seq (
    .clk(clk), .rst_n(rst_i), .key_valid(key_valid), .mode_i(mode),
    .step_i(step), .cnt_o(cnt), .prime_o(prime), .ready_o(key_ready),
    .dec_o(dec), .step_en_o(step_en), .idx_o(round_idx));

  des_ks_cdreg u_cd (
    .clk(clk), .rst_n(rst_i), .key_bits(key_byte[BYTE_W-1:1]),
    .key_valid(key_valid), .cnt_i(cnt), .prime_i(prime), .dec_i(dec),
    .step_en_i(step_en), .idx_i(round_idx), .cd_o(cd));

  des_ks_pc2 u_pc2 (.cd_i(cd), .rk_o(round_key));
endmodule

// File: tb/des_key_sched_ser_tb.sv
`timescale 1ns/1ps
module des_key_sched_ser_tb_top;
  logic clk = 1'b0;
  logic rst_n, key_valid, mode, step;
  logic [7:0] key_byte;
  logic key_ready;
  logic [3:0] round_idx;
  logic [47:0] round_key;

  int nchk = 0, nerr = 0;
  bit live = 0;

  always #4 clk = ~clk;

  des_key_sched_ser dut_i (
    .clk(clk), .rst_n(rst_n), .key_byte(key_byte), .key_valid(key_valid),
    .mode(mode), .step(step), .key_ready(key_ready),
    .round_idx(round_idx), .round_key(round_key));

  localparam int PC1 [56] = '{
    57,49,41,33,25,17,9,1,58,50,42,34,26,18,10,2,59,51,43,35,27,19,11,3,60,52,44,36,
    63,55,47,39,31,23,15,7,62,54,46,38,30,22,14,6,61,53,45,37,29,21,13,5,28,20,12,4};
  localparam int PC2 [48] = '{
    14,17,11,24,1,5,3,28,15,6,21,10,23,19,12,4,26,8,16,7,27,20,13,2,
    41,52,31,37,47,55,30,40,51,45,33,48,44,49,39,56,34,53,46,42,50,36,29,32};

  // schedule from cumulative left offsets, no register rotation
  function automatic logic [47:0] ref_key(input logic [63:0] k, input int rnd);
    int off = 0;
    logic [1:56] cdb;
    logic [47:0] rk;
    for (int r = 1; r <= rnd; r++) off += (r == 1 || r == 2 || r == 9 || r == 16) ? 1 : 2;
    for (int p = 1; p <= 56; p++) cdb[p] = k[64 - PC1[p-1]];
    for (int j = 1; j <= 48; j++) begin
      int q = PC2[j-1];
      int s;
      if (q <= 28) s = ((q - 1 + off) % 28) + 1;
      else         s = ((q - 29 + off) % 28) + 29;
      rk[48-j] = cdb[s];
    end
    return rk;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // cycle model
  logic [7:0] kb [8];
  logic [63:0] mkey;
  int mcnt = 0, midx = 0;
  bit mprime = 0, mready = 0, mmode = 0;

  always @(posedge clk) if (live) begin
    if (key_valid) begin
      kb[mcnt] = key_byte;
      mprime = 0;
      if (mcnt == 7) begin
        mkey = {kb[0], kb[1], kb[2], kb[3], kb[4], kb[5], kb[6], key_byte};
        mmode = mode;
        mprime = 1;
      end
      mready = 0;
      mcnt = (mcnt + 1) % 8;
    end else if (mprime) begin
      mprime = 0; mready = 1; midx = 0;
    end else if (mready && step) begin
      midx = (midx + 1) % 16;
    end
  end

  always @(negedge clk) if (live) begin
    chk("R2 R8 key_ready", {63'd0, key_ready}, {63'd0, mready});
    if (mready) begin
      chk("R6 round_idx", {60'd0, round_idx}, midx);
      if (mmode) chk("R5 R9 decrypt key", {16'd0, round_key}, {16'd0, ref_key(mkey, 16 - midx)});
      else       chk("R4 R9 encrypt key", {16'd0, round_key}, {16'd0, ref_key(mkey, midx + 1)});
    end
  end

  task automatic send_byte(input logic [7:0] b);
    key_byte = b; key_valid = 1'b1;
    @(negedge clk);
    key_valid = 1'b0;
  endtask

  task automatic load_key(input logic [63:0] k, input logic m, input int gap, input int first);
    mode = m;
    for (int i = first; i < 8; i++) begin
      send_byte(k[63 - 8*i -: 8]);
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic step_n(input int n);
    step = 1'b1;
    repeat (n) @(negedge clk);
    step = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog act=running exp=finished");
    summary();
    $finish;
  end

  localparam logic [63:0] KEYA = 64'h133457799BBCDFF1;

  initial begin
    rst_n = 1'b0; key_valid = 1'b0; key_byte = 8'h00; mode = 1'b0; step = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", {63'd0, key_ready}, 64'd0);
    chk("R1 idx in reset", {60'd0, round_idx}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 ready after reset", {63'd0, key_ready}, 64'd0);
    chk("R1 idx after reset", {60'd0, round_idx}, 64'd0);
    live = 1;

    // encrypt order, step held during the setup cycle
    load_key(KEYA, 1'b0, 0, 0);
    chk("R2 ready low at setup", {63'd0, key_ready}, 64'd0);
    step = 1'b1; @(negedge clk); step = 1'b0;
    chk("R2 ready high", {63'd0, key_ready}, 64'd1);
    chk("R7 setup step ignored", {60'd0, round_idx}, 64'd0);
    chk("R4 K1 vector", {16'd0, round_key}, {16'd0, 48'h1B02EFFC7072});
    step_n(1);
    chk("R4 K2 vector", {16'd0, round_key}, {16'd0, 48'h79AED9DBC9E5});
    step_n(14);
    chk("R6 idx 15", {60'd0, round_idx}, 64'd15);
    step_n(1);
    chk("R6 wrap idx", {60'd0, round_idx}, 64'd0);
    chk("R6 wrap key", {16'd0, round_key}, {16'd0, 48'h1B02EFFC7072});
    repeat (5) @(negedge clk);
    chk("R7 hold idx", {60'd0, round_idx}, 64'd0);
    chk("R7 hold key", {16'd0, round_key}, {16'd0, 48'h1B02EFFC7072});
    mode = 1'b1;
    step_n(2);
    chk("R9 mode change ignored", {16'd0, round_key}, {16'd0, ref_key(KEYA, 3)});
    mode = 1'b0;

    // decrypt order with every parity bit flipped
    load_key(KEYA ^ 64'h0101010101010101, 1'b1, 0, 0);
    @(negedge clk);
    chk("R3 R5 K16 first", {16'd0, round_key}, {16'd0, 48'hCB3D8B0E17F5});
    step_n(1);
    chk("R5 K15", {16'd0, round_key}, {16'd0, ref_key(KEYA, 15)});
    mode = 1'b0;
    step_n(17);

    // second key with gaps between bytes
    load_key(64'h0E329232EA6D0D73, 1'b0, 2, 0);
    @(negedge clk);
    step_n(3); repeat (2) @(negedge clk); step_n(5);

    // reload while ready, decrypt order
    mode = 1'b1;
    send_byte(8'hA1);
    chk("R8 ready dropped", {63'd0, key_ready}, 64'd0);
    load_key(64'hA1B2C3D4E5F60718, 1'b1, 1, 1);
    @(negedge clk);
    step_n(20);
    repeat (2) @(negedge clk);

    live = 0;
    summary();
    $finish;
  end
endmodule